// File: doc/BRIEF.md
# Byte-Wise DMA Fetch Engine

This block moves a buffer from memory to a downstream consumer one byte at a time. Software loads a start address and a byte count, then writes a go command. For every byte the engine raises a memory request, waits for the acknowledge, and passes the returned byte on as a one-cycle valid pulse. The address register moves forward and the count register moves toward zero after each accepted byte. Every byte is added into an 8-bit checksum.

The count register holds the two's complement of the buffer length and counts upward. The transfer is finished when the count reaches zero. A per-request watchdog stops the engine if the memory never answers. Two test modes inject faults on purpose. One ignores the memory acknowledge, so the watchdog always fires. The other flags a memory parity error on the first byte fetched. Status flags report busy, done, timeout and parity. Software reads them through the same register port.

The controller is a five-state machine:
- `S_IDLE`: waiting for go.
- `S_REQ`: request raised, waiting for acknowledge or timeout.
- `S_GAP`: one cycle with the request low between bytes.
- `S_DONE`: normal or parity finish.
- `S_FAIL`: timeout finish.

The transitions are:
- IDLE→REQ: go with a non-zero count.
- IDLE→DONE: go with a zero count.
- REQ→GAP: byte accepted and more bytes remain.
- REQ→DONE: last byte accepted, or any byte accepted in parity mode.
- REQ→FAIL: watchdog expired.
- GAP→REQ.
- DONE→IDLE and FAIL→IDLE.

Top module: `dma_byte_engine`

## Requirements
- R1: After reset, every register reads zero and `mem_req` and `out_valid` are low. The registers are: control/status at index 0, address at index 1, count at index 2, checksum at index 3.
- R2: The address and count registers load only on a write with `reg_word` high. A write with `reg_word` low leaves them unchanged.
- R3: After a go with a non-zero count, the engine raises one request per byte. `mem_addr` equals the address register and holds steady while the request waits. The request drops for at least one cycle after each accepted byte.
- R4: Each accepted byte increments the count and the address. When the count reaches zero, busy (status bit 0) clears and done (status bit 1) sets.
- R5: Each accepted byte appears on `out_byte` with `out_valid` high in the cycle after the acknowledge, in address order.
- R6: A go clears the checksum (index 3). Each accepted byte is then added modulo 256.
- R7: If no acknowledge is taken within TMO_CYCLES cycles of raising a request, the engine stops. It drops the request, sets timeout (status bit 2) and done, clears busy, and leaves the count unchanged.
- R8: In test mode 1 (control bits 5:4 = 1) the memory acknowledge is ignored, so every transfer ends by timeout.
- R9: In test mode 2 (control bits 5:4 = 2) the first accepted byte sets parity error (status bit 3). That byte is still delivered and counted, and the transfer then ends with done set.
- R10: While busy, a go, a mode change, or a write to the address or count register has no effect.
- R11: A go with a count of zero sets done without issuing any request.
- R12: The address register wraps modulo 2^ADDR_W.
- R13: Go is control bit 0. A go clears done, timeout and parity, and loads the test mode from bits 5:4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_word | input | 1 | Write covers the full word |
| reg_addr | input | 2 | Register index for writes |
| reg_wdata | input | REG_W | Write data |
| rd_addr | input | 2 | Register index for reads |
| rd_data | output | REG_W | Read data (combinational) |
| mem_req | output | 1 | Memory byte request |
| mem_addr | output | ADDR_W | Byte address of the request |
| mem_ack | input | 1 | Memory acknowledge, data valid |
| mem_data | input | 8 | Byte returned by memory |
| out_valid | output | 1 | Delivered byte valid (one cycle) |
| out_byte | output | 8 | Delivered byte |

## Verification
The bench builds the engine with ADDR_W=8, COUNT_W=8, REG_W=16 and TMO_CYCLES=16. The 8-bit address lets a short buffer started at 0xFE show the wrap to 0x00. The short watchdog means a timeout is reached in a handful of cycles, so the bench can count exactly how long the request stays high. The 8-bit count keeps the two's-complement length values short. The memory model answers with a programmable latency, which covers both back-to-back acknowledges and long waits inside the watchdog window.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_REQ  = 3'd1,
        S_GAP  = 3'd2,
        S_DONE = 3'd3,
        S_FAIL = 3'd4
    } dma_state_t;

    typedef enum logic [1:0] {
        TM_NORMAL    = 2'd0,
        TM_MUTE_ACK  = 2'd1,
        TM_FORCE_PAR = 2'd2,
        TM_SPARE     = 2'd3
    } test_mode_t;

    localparam logic [1:0] RA_CTRL  = 2'd0;
    localparam logic [1:0] RA_ADDR  = 2'd1;
    localparam logic [1:0] RA_COUNT = 2'd2;
    localparam logic [1:0] RA_CKSUM = 2'd3;

    localparam int CTRL_GO_BIT   = 0;
    localparam int CTRL_MODE_LSB = 4;

endpackage

// File: rtl/dma_timer.sv
module dma_timer #(
    parameter int TMO_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int TW = $clog2(TMO_CYCLES + 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run)
            cnt_q <= '0;
        else if (cnt_q != TW'(TMO_CYCLES - 1))
            cnt_q <= cnt_q + TW'(1);
    end

    assign expired = run && (cnt_q == TW'(TMO_CYCLES - 1));

    // R7: the wait counter never passes the window limit
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < TW'(TMO_CYCLES));

endmodule

// File: rtl/dma_cksum.sv
module dma_cksum #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              add,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] sum
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sum <= '0;
        else if (clr)
            sum <= '0;
        else if (add)
            sum <= sum + din;
    end

    // R6: a clear and an add never coincide (go is only taken while idle)
    p_clr_add_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr && add));

endmodule

// File: rtl/dma_fsm.sv
module dma_fsm
    import dma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go_start,
    input  logic       count_zero,
    input  logic       count_last,
    input  logic       ack_eff,
    input  logic       expired,
    input  logic       par_mode,
    output dma_state_t state,
    output logic       mem_req,
    output logic       xfer,
    output logic       finish,
    output logic       fail,
    output logic       busy
);
    dma_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (go_start)
                        state_d = count_zero ? S_DONE : S_REQ;
            S_REQ:  if (ack_eff)
                        state_d = (count_last || par_mode) ? S_DONE : S_GAP;
                    else if (expired)
                        state_d = S_FAIL;
            S_GAP:  state_d = S_REQ;
            S_DONE: state_d = S_IDLE;
            S_FAIL: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        mem_req = 1'b0;
        xfer    = 1'b0;
        finish  = 1'b0;
        fail    = 1'b0;
        busy    = 1'b1;
        unique case (state_q)
            S_IDLE: busy = 1'b0;
            S_REQ: begin
                mem_req = 1'b1;
                xfer    = ack_eff;
            end
            S_GAP:  ;
            S_DONE: finish = 1'b1;
            S_FAIL: begin
                finish = 1'b1;
                fail   = 1'b1;
            end
            default: busy = 1'b0;
        endcase
    end

    assign state = state_q;

    // R7: a timeout finish only follows a waiting request
    p_fail_from_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FAIL) |-> ($past(state_q) == S_REQ));

    // R9: an accepted byte in parity mode ends the transfer
    p_par_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && par_mode) |=> (state_q == S_DONE));

    // R3: the request drops after each accepted byte
    p_req_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> !mem_req);

endmodule

// File: rtl/dma_byte_engine.sv
module dma_byte_engine
    import dma_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int COUNT_W    = 16,
    parameter int REG_W      = 16,
    parameter int TMO_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_word,
    input  logic [1:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic [1:0]        rd_addr,
    output logic [REG_W-1:0]  rd_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [7:0]        mem_data,
    output logic              out_valid,
    output logic [7:0]        out_byte
);
    localparam int BYTE_W = 8;

    dma_state_t        state;
    test_mode_t        mode_q;
    logic [ADDR_W-1:0] addr_q;
    logic [COUNT_W-1:0] cnt_q;
    logic              done_q, tmo_q, par_q;
    logic              go_start, ack_eff, expired, xfer, finish, fail, busy;
    logic              count_zero, count_last;
    logic [BYTE_W-1:0] cksum;
    logic              word_wr_idle;

    assign go_start     = reg_wr && (reg_addr == RA_CTRL) && reg_wdata[CTRL_GO_BIT] && !busy;
    assign word_wr_idle = reg_wr && reg_word && !busy;
    assign ack_eff      = mem_ack && (mode_q != TM_MUTE_ACK);
    assign count_zero   = (cnt_q == '0);
    assign count_last   = (cnt_q == '1);

    dma_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_start   (go_start),
        .count_zero (count_zero),
        .count_last (count_last),
        .ack_eff    (ack_eff),
        .expired    (expired),
        .par_mode   (mode_q == TM_FORCE_PAR),
        .state      (state),
        .mem_req    (mem_req),
        .xfer       (xfer),
        .finish     (finish),
        .fail       (fail),
        .busy       (busy)
    );

    dma_timer #(.TMO_CYCLES(TMO_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state == S_REQ),
        .expired (expired)
    );

    dma_cksum #(.DATA_W(BYTE_W)) u_cksum (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (go_start),
        .add   (xfer),
        .din   (mem_data),
        .sum   (cksum)
    );

    // Mode register: loaded with every control write taken while idle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mode_q <= TM_NORMAL;
        else if (reg_wr && (reg_addr == RA_CTRL) && !busy)
            mode_q <= test_mode_t'(reg_wdata[CTRL_MODE_LSB +: 2]);
    end

    // Address register: full-word load while idle, advance per byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            addr_q <= '0;
        else if (word_wr_idle && (reg_addr == RA_ADDR))
            addr_q <= reg_wdata[ADDR_W-1:0];
        else if (xfer)
            addr_q <= addr_q + ADDR_W'(1);
    end

    // Count register: two's complement length, counts toward zero
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (word_wr_idle && (reg_addr == RA_COUNT))
            cnt_q <= reg_wdata[COUNT_W-1:0];
        else if (xfer)
            cnt_q <= cnt_q + COUNT_W'(1);
    end

    // Status flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            tmo_q  <= 1'b0;
            par_q  <= 1'b0;
        end else if (go_start) begin
            done_q <= 1'b0;
            tmo_q  <= 1'b0;
            par_q  <= 1'b0;
        end else begin
            if (finish)                         done_q <= 1'b1;
            if (fail)                           tmo_q  <= 1'b1;
            if (xfer && mode_q == TM_FORCE_PAR) par_q  <= 1'b1;
        end
    end

    // Downstream byte output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_byte  <= '0;
        end else begin
            out_valid <= xfer;
            if (xfer)
                out_byte <= mem_data;
        end
    end

    assign mem_addr = addr_q;

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            RA_CTRL: begin
                rd_data[0] = busy;
                rd_data[1] = done_q;
                rd_data[2] = tmo_q;
                rd_data[3] = par_q;
                rd_data[CTRL_MODE_LSB +: 2] = mode_q;
            end
            RA_ADDR:  rd_data[ADDR_W-1:0]  = addr_q;
            RA_COUNT: rd_data[COUNT_W-1:0] = cnt_q;
            RA_CKSUM: rd_data[BYTE_W-1:0]  = cksum;
            default:  rd_data = '0;
        endcase
    end

    // R3: the address holds while a request waits unanswered
    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> $stable(mem_addr));

    // R5: a delivered byte follows an acknowledged request
    p_out_after_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(mem_req && mem_ack));

    // R4: done is never shown while a transfer runs
    p_busy_not_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done_q);

    // R10: the count moves only by one per byte while busy
    p_count_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_ack) |=> $stable(cnt_q));

endmodule

// File: tb/dma_byte_engine_bench.sv
module dma_byte_engine_bench;
    localparam int AW  = 8;
    localparam int CW  = 8;
    localparam int RW  = 16;
    localparam int TMO = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0, reg_word = 1'b0;
    logic [1:0]    reg_addr = 2'd0, rd_addr = 2'd0;
    logic [RW-1:0] reg_wdata = '0;
    logic [RW-1:0] rd_data;
    logic          mem_req, mem_ack = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_data = 8'd0;
    logic          out_valid;
    logic [7:0]    out_byte;

    int checks = 0, fails = 0;
    int lat = 0;
    bit ack_en = 1'b1;
    int wait_cnt = 0;
    int req_cycles = 0, req_rises = 0;
    logic req_prev = 1'b0;
    logic [7:0] exp_q[$];

    always #4 clk = ~clk;

    dma_byte_engine #(.ADDR_W(AW), .COUNT_W(CW), .REG_W(RW), .TMO_CYCLES(TMO)) u_dma_byte_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_word(reg_word),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .rd_addr(rd_addr),
        .rd_data(rd_data), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_data(mem_data), .out_valid(out_valid),
        .out_byte(out_byte)
    );

    function automatic logic [7:0] model(input logic [AW-1:0] a);
        return 8'(a * 8'd7 + 8'd3);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // memory responder
    always @(negedge clk) begin
        if (mem_req && ack_en && !mem_ack) begin
            if (wait_cnt >= lat) begin
                mem_ack  <= 1'b1;
                mem_data <= model(mem_addr);
                wait_cnt <= 0;
            end else
                wait_cnt <= wait_cnt + 1;
        end else
            mem_ack <= 1'b0;
    end

    always @(posedge clk) begin
        if (mem_req) req_cycles++;
        if (mem_req && !req_prev) req_rises++;
        req_prev <= mem_req;
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (out_valid) begin
            if (exp_q.size() == 0)
                chk(1'b0, "R5 unexpected byte", {24'd0, out_byte}, 32'd0);
            else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(out_byte == e, "R5 byte order", {24'd0, out_byte}, {24'd0, e});
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [RW-1:0] d, input bit word);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_word = word;
        @(negedge clk);
        reg_wr = 1'b0; reg_word = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [RW-1:0] v);
        @(negedge clk);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    task automatic wait_idle();
        logic [RW-1:0] s;
        for (int i = 0; i < 2000; i++) begin
            rd(2'd0, s);
            if (!s[0]) return;
        end
        chk(1'b0, "R4 busy never cleared", 32'd1, 32'd0);
    endtask

    // driver: push expected bytes, program, go
    task automatic start(input logic [AW-1:0] a, input int n, input int push_n,
                         input logic [1:0] mode, output logic [7:0] sum);
        sum = 8'd0;
        for (int i = 0; i < push_n; i++) begin
            exp_q.push_back(model(AW'(a + AW'(i))));
            sum = sum + model(AW'(a + AW'(i)));
        end
        wr(2'd1, RW'(a), 1'b1);
        wr(2'd2, RW'((256 - n) % 256), 1'b1);
        wr(2'd0, RW'({mode, 4'b0001}), 1'b1);
    endtask

    initial begin
        #(8 * 150000);
        chk(1'b0, "watchdog expired", 32'd0, 32'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [RW-1:0] v;
        logic [7:0] sum;
        int r0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int i = 0; i < 4; i++) begin
            rd(2'(i), v);
            chk(v == '0, "R1 reset register", 32'(v), 32'd0);
        end
        chk(!mem_req && !out_valid, "R1 outputs low", {30'd0, mem_req, out_valid}, 32'd0);

        // R2 byte writes ignored, word writes load
        wr(2'd1, 16'h0033, 1'b0);
        wr(2'd2, 16'h0044, 1'b0);
        rd(2'd1, v); chk(v == 16'h0, "R2 addr byte write", 32'(v), 32'd0);
        rd(2'd2, v); chk(v == 16'h0, "R2 count byte write", 32'(v), 32'd0);
        wr(2'd1, 16'h0033, 1'b1);
        rd(2'd1, v); chk(v == 16'h0033, "R2 addr word write", 32'(v), 32'h33);

        // R3 R4 R5 R6 R13 basic transfer, zero latency
        lat = 0;
        r0 = req_rises;
        start(8'h10, 5, 5, 2'd0, sum);
        wait_idle();
        rd(2'd0, v); chk(v[3:0] == 4'b0010, "R4 R13 done status", 32'(v[3:0]), 32'h2);
        rd(2'd1, v); chk(v == 16'h15, "R4 addr advanced", 32'(v), 32'h15);
        rd(2'd2, v); chk(v == 16'h0, "R4 count zero", 32'(v), 32'd0);
        rd(2'd3, v); chk(v[7:0] == sum, "R6 checksum", 32'(v), 32'(sum));
        chk(req_rises - r0 == 5, "R3 one request per byte", 32'(req_rises - r0), 32'd5);
        chk(exp_q.size() == 0, "R5 all bytes seen", 32'(exp_q.size()), 32'd0);

        // R12 R10 wrap with latency, writes while busy ignored
        lat = 3;
        start(8'hFE, 4, 4, 2'd0, sum);
        repeat (2) @(negedge clk);
        wr(2'd1, 16'h0055, 1'b1);
        wr(2'd2, 16'h0007, 1'b1);
        wr(2'd0, 16'h0021, 1'b1);
        wait_idle();
        rd(2'd1, v); chk(v == 16'h02, "R12 address wrap", 32'(v), 32'h2);
        rd(2'd2, v); chk(v == 16'h0, "R10 count write ignored", 32'(v), 32'd0);
        rd(2'd0, v); chk(v[5:0] == 6'b000010, "R10 mode/go ignored", 32'(v[5:0]), 32'h2);
        rd(2'd3, v); chk(v[7:0] == sum, "R6 checksum restart", 32'(v), 32'(sum));
        chk(exp_q.size() == 0, "R5 no extra bytes", 32'(exp_q.size()), 32'd0);

        // R11 zero count
        r0 = req_rises;
        wr(2'd2, 16'h0000, 1'b1);
        wr(2'd0, 16'h0001, 1'b1);
        wait_idle();
        rd(2'd0, v); chk(v[2:0] == 3'b010, "R11 done without request", 32'(v[2:0]), 32'h2);
        chk(req_rises == r0, "R11 no request", 32'(req_rises - r0), 32'd0);
        rd(2'd3, v); chk(v == 16'h0, "R6 checksum cleared at go", 32'(v), 32'd0);

        // R7 no acknowledge at all
        lat = 0;
        ack_en = 1'b0;
        req_cycles = 0;
        start(8'h40, 3, 0, 2'd0, sum);
        wait_idle();
        ack_en = 1'b1;
        chk(req_cycles == TMO, "R7 request window", 32'(req_cycles), 32'(TMO));
        rd(2'd0, v); chk(v[3:0] == 4'b0110, "R7 timeout status", 32'(v[3:0]), 32'h6);
        rd(2'd2, v); chk(v == 16'hFD, "R7 count unchanged", 32'(v), 32'hFD);
        chk(!mem_req, "R7 request dropped", 32'(mem_req), 32'd0);

        // R8 acknowledge muted by test mode
        req_cycles = 0;
        start(8'h50, 2, 0, 2'd1, sum);
        wait_idle();
        rd(2'd0, v); chk(v[5:0] == 6'b010110, "R8 muted ack times out", 32'(v[5:0]), 32'h16);
        chk(req_cycles == TMO, "R8 request window", 32'(req_cycles), 32'(TMO));
        chk(exp_q.size() == 0, "R8 no bytes delivered", 32'(exp_q.size()), 32'd0);

        // R9 forced parity
        start(8'h60, 4, 1, 2'd2, sum);
        wait_idle();
        rd(2'd0, v); chk(v[5:0] == 6'b101010, "R9 parity status", 32'(v[5:0]), 32'h2A);
        rd(2'd2, v); chk(v == 16'hFD, "R9 one byte counted", 32'(v), 32'hFD);
        rd(2'd1, v); chk(v == 16'h61, "R9 address advanced once", 32'(v), 32'h61);
        rd(2'd3, v); chk(v[7:0] == sum, "R9 R6 checksum", 32'(v), 32'(sum));
        chk(exp_q.size() == 0, "R9 byte delivered", 32'(exp_q.size()), 32'd0);

        // R13 next go clears error flags
        start(8'h70, 1, 1, 2'd0, sum);
        wait_idle();
        rd(2'd0, v); chk(v[5:0] == 6'b000010, "R13 flags cleared", 32'(v[5:0]), 32'h2);

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule